// File: doc/BRIEF.md
# Hub Status Change Interrupt Endpoint

This block holds the change bitmap that a hub reports on its interrupt endpoint. Change events come in from the hub logic and from each downstream port. Each event is latched at once into a pending bit. At the end-of-frame sampling marker, the pending bits are moved into the reported byte, ready for polls in the next frame. When the host polls with an IN token, the block chooses the handshake. An empty byte gets a NAK. Any set bit sends the whole byte as the data payload.

A reported bit stays set through every poll and every later frame until the host clears it with a clear request that names its bit index. The block stays fully silent while the hub is not configured. Dropping the configured flag clears every pending and reported bit. Packet serialization and data toggling belong to neighbouring logic, which reads the handshake select and the byte from this block.

Top module: `scr_status_ep`

## Requirements
- R1: After reset, with the hub configured and no events seen, an IN token is answered with a NAK and a zero byte.
- R2: Byte bit 0 reports a hub-level change (event input bit 0), and bit k reports a change on port k (event input bit k, k = 1..NUM_PORTS). Bits above NUM_PORTS always read 0.
- R3: An event reaches the reported byte only at the next end-of-frame sample. An IN token before that sample does not show it.
- R4: An IN token gets a NAK (rsp_is_data_o = 0) exactly when every bit of the reported byte is 0.
- R5: When any reported bit is set, the response is DATA (rsp_is_data_o = 1), and rsp_byte_o carries the whole reported byte as it stood in the cycle of the token.
- R6: A reported bit stays set across repeated polls and across later end-of-frame samples until a clear request names its index.
- R7: A clear request with index i (0 = hub, k = port k) removes bit i from both the reported and pending state and leaves every other bit alone. An index above NUM_PORTS has no effect.
- R8: While the configured flag is low, IN tokens get no response (rsp_vld_o stays 0), and change events are discarded.
- R9: A clear request and a new event for the same bit in the same cycle leave that bit set after the next end-of-frame sample.
- R10: Dropping the configured flag clears all pending and reported bits, so after reconfiguration the next poll is a NAK.
- R11: rsp_vld_o is a single-cycle pulse in the cycle after each IN token taken while configured.
- R12: An event that arrives in the same cycle as the end-of-frame marker is included in that sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_i | input | 1 | Hub is enumerated and configured |
| evt_i | input | NUM_PORTS+1 | Change event strobes; bit 0 hub, bit k port k |
| eof2_i | input | 1 | End-of-frame sampling marker, one cycle |
| in_tok_i | input | 1 | IN token addressed to this endpoint, one cycle |
| clr_vld_i | input | 1 | Clear request strobe |
| clr_idx_i | input | 3 | Bit index the clear request removes |
| rsp_vld_o | output | 1 | Response is valid this cycle |
| rsp_is_data_o | output | 1 | 1 = send DATA with rsp_byte_o, 0 = send NAK |
| rsp_byte_o | output | 8 | Status change byte to send |

## Verification
The bench builds the block with its default of four ports. Clear index 5 is then the first out-of-range value, and index 7 is the widest the 3-bit field carries, so both ignore paths of R7 are exercised. Reserved bits 5 to 7 of the byte are observable on every response. The fixed event/clear/sample/poll vector walk covers the bitmap ordering and persistence. Directed cases then place an event on the sampling cycle, a clear together with an event on one bit, and a deconfigure in the middle of a frame.

// File: rtl/scr_pkg.sv
package scr_pkg;

  localparam int unsigned SCR_BYTE_W = 8;
  localparam int unsigned SCR_IDX_W  = $clog2(SCR_BYTE_W);

  // One-hot mask for a clear request; zero when not valid or out of range.
  function automatic logic [SCR_BYTE_W-1:0] clr_mask_f(
    input logic                 vld,
    input logic [SCR_IDX_W-1:0] idx,
    input int unsigned          top_idx
  );
    logic [SCR_BYTE_W-1:0] m;
    m = '0;
    if (vld && (int'(idx) <= int'(top_idx))) m[idx] = 1'b1;
    return m;
  endfunction

  // Next reported bit: sample pending on the marker, then clear, then a
  // same-cycle event on the marker lands straight in the report.
  function automatic logic rpt_next_f(
    input logic rpt, input logic pend, input logic evt,
    input logic smp, input logic clr
  );
    logic v;
    v = smp ? (rpt | pend) : rpt;
    v = v & ~clr;
    return smp ? (v | evt) : v;
  endfunction

  // Next pending bit: emptied on the marker, otherwise clear then set.
  function automatic logic pend_next_f(
    input logic pend, input logic evt, input logic smp, input logic clr
  );
    return smp ? 1'b0 : ((pend & ~clr) | evt);
  endfunction

endpackage

// File: rtl/scr_bit_cell.sv
module scr_bit_cell
  import scr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_i,
  input  logic evt_i,
  input  logic smp_i,
  input  logic clr_i,
  output logic rpt_o,
  output logic pend_o
);

  logic rpt_q, pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rpt_q  <= 1'b0;
      pend_q <= 1'b0;
    end else if (!cfg_i) begin
      rpt_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      rpt_q  <= rpt_next_f(rpt_q, pend_q, evt_i, smp_i, clr_i);
      pend_q <= pend_next_f(pend_q, evt_i, smp_i, clr_i);
    end
  end

  assign rpt_o  = rpt_q;
  assign pend_o = pend_q;

endmodule

// File: rtl/scr_change_store.sv
module scr_change_store
  import scr_pkg::*;
#(
  parameter int unsigned NUM_SRC = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_i,
  input  logic [NUM_SRC-1:0]    evt_i,
  input  logic                  smp_i,
  input  logic [NUM_SRC-1:0]    clr_i,
  output logic [SCR_BYTE_W-1:0] rpt_o,
  output logic [NUM_SRC-1:0]    pend_o
);

  logic [NUM_SRC-1:0] rpt_bits;

  for (genvar g = 0; g < SCR_BYTE_W; g++) begin : g_bit
    if (g < NUM_SRC) begin : g_live
      scr_bit_cell u_cell (
        .clk    (clk),
        .rst_n  (rst_n),
        .cfg_i  (cfg_i),
        .evt_i  (evt_i[g]),
        .smp_i  (smp_i),
        .clr_i  (clr_i[g]),
        .rpt_o  (rpt_bits[g]),
        .pend_o (pend_o[g])
      );
      assign rpt_o[g] = rpt_bits[g];
    end else begin : g_rsvd
      assign rpt_o[g] = 1'b0;
    end
  end

endmodule

// File: rtl/scr_in_responder.sv
module scr_in_responder
  import scr_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  take_i,
  input  logic [SCR_BYTE_W-1:0] rpt_i,
  output logic                  rsp_vld_o,
  output logic                  rsp_is_data_o,
  output logic [SCR_BYTE_W-1:0] rsp_byte_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_vld_o     <= 1'b0;
      rsp_is_data_o <= 1'b0;
      rsp_byte_o    <= '0;
    end else begin
      rsp_vld_o <= take_i;
      if (take_i) begin
        rsp_is_data_o <= |rpt_i;
        rsp_byte_o    <= rpt_i;
      end
    end
  end

endmodule

// File: rtl/scr_status_ep.sv
module scr_status_ep
  import scr_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_i,
  input  logic [NUM_PORTS:0]         evt_i,
  input  logic                       eof2_i,
  input  logic                       in_tok_i,
  input  logic                       clr_vld_i,
  input  logic [SCR_IDX_W-1:0]       clr_idx_i,
  output logic                       rsp_vld_o,
  output logic                       rsp_is_data_o,
  output logic [SCR_BYTE_W-1:0]      rsp_byte_o
);

  localparam int unsigned NUM_SRC = NUM_PORTS + 1;

  // Named internal events, visible to the bound checker.
  logic [SCR_BYTE_W-1:0] clr_mask_w;
  logic [SCR_BYTE_W-1:0] rpt_byte_w;
  logic [NUM_SRC-1:0]    pend_w;
  logic                  take_w;
  logic                  any_change_w;

  assign clr_mask_w   = clr_mask_f(clr_vld_i, clr_idx_i, NUM_PORTS);
  assign take_w       = in_tok_i & cfg_i;
  assign any_change_w = |rpt_byte_w;

  scr_change_store #(.NUM_SRC(NUM_SRC)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .cfg_i  (cfg_i),
    .evt_i  (evt_i),
    .smp_i  (eof2_i),
    .clr_i  (clr_mask_w[NUM_SRC-1:0]),
    .rpt_o  (rpt_byte_w),
    .pend_o (pend_w)
  );

  scr_in_responder u_rsp (
    .clk           (clk),
    .rst_n         (rst_n),
    .take_i        (take_w),
    .rpt_i         (rpt_byte_w),
    .rsp_vld_o     (rsp_vld_o),
    .rsp_is_data_o (rsp_is_data_o),
    .rsp_byte_o    (rsp_byte_o)
  );

endmodule

// File: rtl/scr_status_ep_chk.sv
module scr_status_ep_chk
  import scr_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cfg_i,
  input logic                  eof2_i,
  input logic                  in_tok_i,
  input logic                  clr_vld_i,
  input logic                  rsp_vld_o,
  input logic                  rsp_is_data_o,
  input logic [SCR_BYTE_W-1:0] rsp_byte_o,
  input logic [SCR_BYTE_W-1:0] rpt_byte_w
);

  // R11
  rsp_follows_tok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_tok_i && cfg_i) |=> rsp_vld_o);

  // R8
  silent_unconfigured_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_tok_i && cfg_i) |=> !rsp_vld_o);

  // R4
  hs_matches_payload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_vld_o |-> (rsp_is_data_o == (rsp_byte_o != '0)));

  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_vld_o |-> ((rsp_byte_o >> (NUM_PORTS + 1)) == '0));

  // R10
  deconfig_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_i |=> (rpt_byte_w == '0));

  // R6
  report_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_i && !eof2_i && !clr_vld_i) |=> $stable(rpt_byte_w));

  // R5
  payload_is_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_tok_i && cfg_i) |=> (rsp_byte_o == $past(rpt_byte_w)));

endmodule

bind scr_status_ep scr_status_ep_chk #(.NUM_PORTS(NUM_PORTS)) u_chk (.*);

// File: tb/scr_status_ep_tb.sv
`timescale 1ns/1ps
module scr_status_ep_tb;

  localparam int NP = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_i = 1'b0;
  logic [NP:0]   evt_i = '0;
  logic          eof2_i = 1'b0;
  logic          in_tok_i = 1'b0;
  logic          clr_vld_i = 1'b0;
  logic [2:0]    clr_idx_i = '0;
  logic          rsp_vld_o;
  logic          rsp_is_data_o;
  logic [7:0]    rsp_byte_o;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  scr_status_ep #(.NUM_PORTS(NP)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_i(cfg_i), .evt_i(evt_i),
    .eof2_i(eof2_i), .in_tok_i(in_tok_i), .clr_vld_i(clr_vld_i),
    .clr_idx_i(clr_idx_i), .rsp_vld_o(rsp_vld_o),
    .rsp_is_data_o(rsp_is_data_o), .rsp_byte_o(rsp_byte_o)
  );

  // Vector: {events[4:0], clear_en, clear_idx[2:0], expected byte[7:0]}
  localparam logic [16:0] VEC [8] = '{
    {5'b00010, 1'b0, 3'd0, 8'h02},
    {5'b10000, 1'b0, 3'd0, 8'h12},
    {5'b00000, 1'b1, 3'd1, 8'h10},
    {5'b00001, 1'b1, 3'd7, 8'h11},
    {5'b00000, 1'b1, 3'd4, 8'h01},
    {5'b00000, 1'b1, 3'd0, 8'h00},
    {5'b01100, 1'b0, 3'd0, 8'h0C},
    {5'b00000, 1'b1, 3'd5, 8'h0C}
  };

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse_evt(input logic [NP:0] e);
    @(negedge clk) evt_i = e;
    @(negedge clk) evt_i = '0;
  endtask

  task automatic pulse_clr(input logic [2:0] idx);
    @(negedge clk) begin clr_vld_i = 1'b1; clr_idx_i = idx; end
    @(negedge clk) clr_vld_i = 1'b0;
  endtask

  task automatic pulse_eof2();
    @(negedge clk) eof2_i = 1'b1;
    @(negedge clk) eof2_i = 1'b0;
  endtask

  // Token held for one edge; response sampled at the following negedge.
  task automatic poll(input string tag, input logic exp_vld, input logic [7:0] exp_b);
    @(negedge clk) in_tok_i = 1'b1;
    @(negedge clk) in_tok_i = 1'b0;
    check(rsp_vld_o == exp_vld, {tag, " vld"}, rsp_vld_o, exp_vld);
    if (exp_vld) begin
      check(rsp_byte_o == exp_b, {tag, " byte"}, rsp_byte_o, exp_b);
      check(rsp_is_data_o == (exp_b != 8'h00), {tag, " hs"}, rsp_is_data_o, exp_b != 8'h00);
    end
    @(negedge clk);
    check(rsp_vld_o == 1'b0, {tag, " R11 pulse"}, rsp_vld_o, 0);
  endtask

  initial begin
    #(200000 * 8);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(rsp_vld_o == 1'b0, "R1 reset vld", rsp_vld_o, 0);
    rst_n = 1'b1;
    @(negedge clk) cfg_i = 1'b1;
    poll("R1 R4 first poll", 1'b1, 8'h00);

    // Table walk: R2 R5 R6 R7
    for (int i = 0; i < 8; i++) begin
      logic [16:0] v;
      v = VEC[i];
      if (v[16:12] != '0) pulse_evt(v[16:12]);
      if (v[11]) pulse_clr(v[10:8]);
      pulse_eof2();
      poll($sformatf("R2 R5 R7 vec%0d", i), 1'b1, v[7:0]);
    end

    // R6: repeat polls and another frame, still reported
    poll("R6 repoll", 1'b1, 8'h0C);
    pulse_eof2();
    poll("R6 after frame", 1'b1, 8'h0C);
    pulse_clr(3'd2);
    pulse_clr(3'd3);
    poll("R4 cleared", 1'b1, 8'h00);

    // R3: event not visible before the sample
    pulse_evt(5'b00100);
    poll("R3 before sample", 1'b1, 8'h00);
    pulse_eof2();
    poll("R3 after sample", 1'b1, 8'h04);
    pulse_clr(3'd2);

    // R12: event on the marker cycle
    @(negedge clk) begin eof2_i = 1'b1; evt_i = 5'b01000; end
    @(negedge clk) begin eof2_i = 1'b0; evt_i = '0; end
    poll("R12 same cycle", 1'b1, 8'h08);

    // R9: clear and event on bit 3 together
    @(negedge clk) begin clr_vld_i = 1'b1; clr_idx_i = 3'd3; evt_i = 5'b01000; end
    @(negedge clk) begin clr_vld_i = 1'b0; evt_i = '0; end
    poll("R9 before sample", 1'b1, 8'h00);
    pulse_eof2();
    poll("R9 after sample", 1'b1, 8'h08);

    // R10: deconfigure clears everything, including pending
    pulse_evt(5'b00001);
    @(negedge clk) cfg_i = 1'b0;
    // R8: silent and events dropped while unconfigured
    poll("R8 silent", 1'b0, 8'h00);
    pulse_evt(5'b10010);
    pulse_eof2();
    poll("R8 still silent", 1'b0, 8'h00);
    @(negedge clk) cfg_i = 1'b1;
    pulse_eof2();
    poll("R10 R8 after reconfig", 1'b1, 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule